// File: doc/BRIEF.md
# Multiplexed-Address Dynamic RAM Model

This block is a clock-sampled, synthesizable behavioural model of a 16K x 1 dynamic memory. The memory is arranged as 128 rows of 128 single-bit columns. Row and column addresses share one 7-bit bus. The active-low row strobe, column strobe and write-enable are sampled on a fast system clock, and the block reacts to their edges. A falling row strobe selects a row and copies it into an open-row buffer. A falling column strobe selects a bit in that buffer. A rising row strobe writes the buffer back into the array.

The data output is modelled as a registered value plus a drive-enable, which stands in for a tri-state pin. The block supports plain reads, early writes, late writes (read-modify-write), several column accesses inside one row activation (page mode), and row-only refresh cycles.

Each row has an age counter that counts system clocks since the row was last activated. A row that lapses past a parameterised retention limit raises a sticky flag. A testbench can read these flags to catch a missed refresh.

Top module: `dram_mux_model`

## Requirements
- R1: A bit written at row r, column c (row taken from `addr` at the row-strobe fall, column from `addr` at the column-strobe fall) reads back unchanged. Writing another (row, column) pair, including the pair with r and c swapped, does not disturb it.
- R2: After reset the block ignores strobes until the row strobe falls. The column strobe must be high when the row strobe falls and for the next sampled clock. The first column access is taken on the second sampled clock after the row fall, or later.
- R3: `dout_oe` is high only after a column-strobe fall that was sampled while the row strobe was low. It drops on the clock edge that samples the column strobe high, or the row strobe high.
- R4: A row cycle in which the column strobe stays high never raises `dout_oe`, and it leaves the stored contents of that row unchanged.
- R5: While the row strobe stays low, each new column-strobe fall reaches a new column of the same open row. Writes made in the page are seen by later reads in the same page, and again after the row is closed and reopened.
- R6: If `we_n` is low when the column-strobe fall is sampled, the cycle is an early write. `din` is stored at that column and `dout_oe` stays low for the whole column access.
- R7: If `we_n` falls while the column strobe is low in a read access, `din` is stored at the selected column. `dout` keeps the value read before the write until the column strobe rises.
- R8: Each row has an age counter in system clocks, cleared by any row-strobe fall addressing that row. Bit r of `row_stale` is set once row r has gone more than `RETENTION_CLKS`+1 clocks without activation. A row activated within the last `RETENTION_CLKS` clocks that has not lapsed keeps its bit clear.
- R9: A set `row_stale` bit stays set even if the row is activated afterwards. Only `rst` clears it.
- R10: While `rst` is high and on the first clock after it, `dout_oe` is 0, `dout` is 0 and `row_stale` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Shared row/column address bus |
| din | input | 1 | Write data |
| dout | output | 1 | Read data, meaningful while `dout_oe` is high |
| dout_oe | output | 1 | Output drive enable (low means high impedance) |
| row_stale | output | 2**ADDR_W | Sticky per-row missed-refresh flags |

## Verification
The assertions assume that the strobes follow the memory's timing discipline. The column strobe is high when the row strobe falls and for one clock after it, and the row strobe rises only after the column strobe has been sampled high for at least one clock. Write-enable falls during a column access only to request a late write. The bench drives every input on the falling clock edge. Each of its row tasks adds the required idle samples between the two strobes, so the stimulus never breaks these rules. The refresh sweep is placed so that one chosen row lapses while all other rows stay inside the retention window.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

  typedef enum logic [1:0] {
    ROW_IDLE,
    ROW_LOAD,
    ROW_OPEN
  } row_state_e;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_READ,
    ACC_EWRITE,
    ACC_RMW
  } acc_kind_e;

  typedef struct packed {
    logic fell;
    logic rose;
  } strobe_evt_t;

endpackage

// File: rtl/dram_strobe_edge.sv
module dram_strobe_edge
  import dram_mux_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sig_n,
  output strobe_evt_t evt
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sig_n;
  end

  always_comb begin
    evt.fell = prev_q & ~sig_n;
    evt.rose = ~prev_q & sig_n;
  end

endmodule

// File: rtl/dram_row_array.sv
module dram_row_array #(
  parameter int ADDR_W = 7,
  parameter int WIDTH  = 128
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= cells[rd_addr];
  end

endmodule

// File: rtl/dram_refresh_monitor.sv
module dram_refresh_monitor #(
  parameter int ADDR_W         = 7,
  parameter int RETENTION_CLKS = 2000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 act,
  input  logic [ADDR_W-1:0]    act_row,
  output logic [(1<<ADDR_W)-1:0] stale
);

  localparam int ROWS  = 1 << ADDR_W;
  localparam int AGE_W = $clog2(RETENTION_CLKS + 1);
  localparam logic [AGE_W-1:0] AGE_LIMIT = AGE_W'(RETENTION_CLKS);

  for (genvar gi = 0; gi < ROWS; gi++) begin : g_row
    logic [AGE_W-1:0] age_q;
    logic             hit;

    assign hit = act && (act_row == ADDR_W'(gi));

    always_ff @(posedge clk) begin
      if (rst) begin
        age_q     <= '0;
        stale[gi] <= 1'b0;
      end else begin
        if (hit)                     age_q <= '0;
        else if (age_q != AGE_LIMIT) age_q <= age_q + AGE_W'(1);
        if (age_q == AGE_LIMIT)      stale[gi] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dram_mux_model.sv
module dram_mux_model
  import dram_mux_pkg::*;
#(
  parameter int ADDR_W         = 7,
  parameter int RETENTION_CLKS = 2000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   din,
  output logic                   dout,
  output logic                   dout_oe,
  output logic [(1<<ADDR_W)-1:0] row_stale
);

  localparam int ROWS = 1 << ADDR_W;
  localparam int COLS = 1 << ADDR_W;
  localparam int NSTB = 3;

  // strobe index map: 0 row, 1 column, 2 write
  logic [NSTB-1:0] strobe_raw;
  strobe_evt_t     evt [NSTB];

  assign strobe_raw = {we_n, cas_n, ras_n};

  for (genvar gs = 0; gs < NSTB; gs++) begin : g_edge
    dram_strobe_edge u_edge (
      .clk   (clk),
      .rst   (rst),
      .sig_n (strobe_raw[gs]),
      .evt   (evt[gs])
    );
  end

  logic ras_fell, ras_rose, cas_fell, cas_rose, we_fell;
  logic unused_we_rose;

  assign ras_fell       = evt[0].fell;
  assign ras_rose       = evt[0].rose;
  assign cas_fell       = evt[1].fell;
  assign cas_rose       = evt[1].rose;
  assign we_fell        = evt[2].fell;
  assign unused_we_rose = evt[2].rose;

  row_state_e        state_q;
  acc_kind_e         acc_q;
  logic [ADDR_W-1:0] row_q;
  logic [ADDR_W-1:0] col_q;
  logic [COLS-1:0]   row_buf;
  logic [COLS-1:0]   arr_rd_data;
  logic              arr_rd_en;
  logic              arr_wr_en;
  logic              activate;

  assign activate  = (state_q == ROW_IDLE) && ras_fell;
  assign arr_rd_en = activate;
  assign arr_wr_en = (state_q == ROW_OPEN) && ras_rose;

  dram_row_array #(
    .ADDR_W (ADDR_W),
    .WIDTH  (COLS)
  ) u_array (
    .clk     (clk),
    .rd_en   (arr_rd_en),
    .rd_addr (addr),
    .rd_data (arr_rd_data),
    .wr_en   (arr_wr_en),
    .wr_addr (row_q),
    .wr_data (row_buf)
  );

  dram_refresh_monitor #(
    .ADDR_W         (ADDR_W),
    .RETENTION_CLKS (RETENTION_CLKS)
  ) u_refresh (
    .clk     (clk),
    .rst     (rst),
    .act     (activate),
    .act_row (addr),
    .stale   (row_stale)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ROW_IDLE;
      acc_q   <= ACC_NONE;
      row_q   <= '0;
      col_q   <= '0;
      row_buf <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      unique case (state_q)
        ROW_IDLE: begin
          if (ras_fell) begin
            row_q   <= addr;
            state_q <= ROW_LOAD;
          end
        end
        ROW_LOAD: begin
          row_buf <= arr_rd_data;
          state_q <= ras_rose ? ROW_IDLE : ROW_OPEN;
        end
        ROW_OPEN: begin
          if (ras_rose) begin
            state_q <= ROW_IDLE;
            acc_q   <= ACC_NONE;
            dout    <= 1'b0;
            dout_oe <= 1'b0;
          end else if (cas_fell) begin
            col_q <= addr;
            if (!we_n) begin
              row_buf[addr] <= din;
              acc_q         <= ACC_EWRITE;
              dout_oe       <= 1'b0;
            end else begin
              dout    <= row_buf[addr];
              dout_oe <= 1'b1;
              acc_q   <= ACC_READ;
            end
          end else if (cas_rose) begin
            acc_q   <= ACC_NONE;
            dout    <= 1'b0;
            dout_oe <= 1'b0;
          end else if (acc_q == ACC_READ && we_fell) begin
            row_buf[col_q] <= din;
            acc_q          <= ACC_RMW;
          end
        end
        default: state_q <= ROW_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_mux_checker.sv
module dram_mux_checker #(
  parameter int ROWS = 128
) (
  input logic            clk,
  input logic            rst,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic            dout,
  input logic            dout_oe,
  input logic [ROWS-1:0] row_stale
);

  // R2: column strobe high at the row fall and one clock after
  assert_cas_high_at_row_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> cas_n);
  assert_cas_gap_after_row_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |=> cas_n);

  // R3: row closes only after the column strobe is high
  assert_row_close_order_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (cas_n && $past(cas_n)));

  // R3: drive needs both strobes low on the previous sample
  assert_drive_needs_strobes_R3: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> ($past(!cas_n) && $past(!ras_n)));

  // R4: no drive while the column strobe stays high
  assert_refresh_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (cas_n && $past(cas_n)) |-> !dout_oe);

  // R6: early write keeps the output released
  assert_early_write_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && !we_n && !ras_n) |=> !dout_oe);

  // R7: driven data does not change within one column access
  assert_dout_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && $past(dout_oe)) |-> $stable(dout));

  // R9: stale flags never clear without reset
  assert_stale_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ((row_stale & $past(row_stale)) == $past(row_stale)));

endmodule

bind dram_mux_model dram_mux_checker #(.ROWS(1 << ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .dout      (dout),
  .dout_oe   (dout_oe),
  .row_stale (row_stale)
);

// File: tb/sim_dram_mux_model.sv
`timescale 1ns/1ps
module sim_dram_mux_model;

  localparam int AW  = 7;
  localparam int RET = 1500;
  localparam logic [15:0] PAT = 16'hA5C3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0]  addr = '0;
  logic           din = 1'b0;
  logic           dout, dout_oe;
  logic [127:0]   row_stale;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int oe_bad   = 0;
  bit sweep_on = 1'b0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  dram_mux_model #(.ADDR_W(AW), .RETENTION_CLKS(RET)) u0 (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .row_stale(row_stale)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (sweep_on && dout_oe) oe_bad <= oe_bad + 1;
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ras_open(input logic [AW-1:0] r);
    addr = r; ras_n = 1'b0; tick(); tick();
  endtask

  task automatic ras_close();
    ras_n = 1'b1; tick(); tick();
  endtask

  task automatic cas_read(input logic [AW-1:0] c, input logic e, input string tag);
    addr = c; we_n = 1'b1; cas_n = 1'b0; tick();
    check({tag, " drive"}, 128'(dout_oe), 128'(1));
    check({tag, " data"}, 128'(dout), 128'(e));
    cas_n = 1'b1; tick();
    check("R3 release after column rise", 128'(dout_oe), 128'(0));
  endtask

  task automatic early_write(input logic [AW-1:0] c, input logic d);
    addr = c; din = d; we_n = 1'b0; cas_n = 1'b0; tick();
    check("R6 early write keeps output off", 128'(dout_oe), 128'(0));
    cas_n = 1'b1; we_n = 1'b1; tick();
  endtask

  task automatic rmw(input logic [AW-1:0] c, input logic d, input logic old);
    addr = c; we_n = 1'b1; cas_n = 1'b0; tick();
    check("R7 read part drive", 128'(dout_oe), 128'(1));
    check("R7 read part data", 128'(dout), 128'(old));
    din = d; we_n = 1'b0; tick();
    check("R7 output holds old value", 128'(dout), 128'(old));
    tick();
    check("R7 still driven", 128'(dout_oe), 128'(1));
    cas_n = 1'b1; we_n = 1'b1; tick();
    check("R3 release after late write", 128'(dout_oe), 128'(0));
  endtask

  task automatic refresh_row(input logic [AW-1:0] r);
    addr = r; ras_n = 1'b0; tick(); tick(); tick();
    ras_n = 1'b1; tick(); tick();
  endtask

  task automatic t_reset();
    check("R10 reset dout_oe", 128'(dout_oe), 128'(0));
    check("R10 reset dout", 128'(dout), 128'(0));
    check("R10 reset row_stale", row_stale, 128'(0));
  endtask

  task automatic t_single_bits();
    ras_open(3);  early_write(10, 1'b1); ras_close();
    ras_open(10); early_write(3, 1'b0);  ras_close();
    ras_open(3);  early_write(11, 1'b0); ras_close();
    ras_open(4);  early_write(10, 1'b0); ras_close();
    ras_open(3);
    cas_read(10, 1'b1, "R1 row3 col10");
    cas_read(11, 1'b0, "R1 row3 col11");
    ras_close();
    ras_open(10); cas_read(3, 1'b0, "R1 swapped row10 col3"); ras_close();
    ras_open(4);  cas_read(10, 1'b0, "R1 row4 col10");        ras_close();
  endtask

  task automatic t_page();
    ras_open(20);
    for (int i = 0; i < 16; i++) early_write(AW'(i), PAT[i]);
    for (int i = 0; i < 16; i++) cas_read(AW'(i), PAT[i], "R5 same page read");
    ras_close();
    ras_open(20);
    for (int i = 15; i >= 0; i--) cas_read(AW'(i), PAT[i], "R5 reopened page read");
    ras_close();
  endtask

  task automatic t_rmw();
    ras_open(3);
    rmw(10, 1'b0, 1'b1);
    cas_read(10, 1'b0, "R7 new value in same page");
    ras_close();
    ras_open(20);
    rmw(2, 1'b1, PAT[2]);
    ras_close();
    ras_open(20); cas_read(2, 1'b1, "R7 new value after reopen"); ras_close();
  endtask

  task automatic t_sweep();
    sweep_on = 1'b1;
    for (int r = 0; r < 128; r++) if (r != 9) refresh_row(AW'(r));
    sweep_on = 1'b0;
    check("R4 no drive during row-only cycles", 128'(oe_bad), 128'(0));
    ras_open(3);
    cas_read(10, 1'b0, "R4 data kept row3 col10");
    cas_read(11, 1'b0, "R4 data kept row3 col11");
    ras_close();
    ras_open(20);
    cas_read(2, 1'b1, "R4 data kept row20 col2");
    cas_read(0, PAT[0], "R4 data kept row20 col0");
    ras_close();
  endtask

  task automatic t_stale();
    while (cyc < RET + 40) tick();
    check("R8 only unrefreshed row flagged", row_stale, 128'(1) << 9);
    refresh_row(9);
    tick();
    check("R9 flag stays after late refresh", 128'(row_stale[9]), 128'(1));
    repeat (RET + 20) tick();
    check("R8 all rows lapse", row_stale, ~128'(0));
  endtask

  task automatic t_reset_clear();
    rst = 1'b1; tick(); tick();
    check("R10 flags clear in reset", row_stale, 128'(0));
    rst = 1'b0; tick();
    check("R10 flags clear after reset", row_stale, 128'(0));
    check("R10 output off after reset", 128'(dout_oe), 128'(0));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst = 1'b0;
    tick();
    t_reset();
    t_single_bits();
    t_page();
    t_rmw();
    t_sweep();
    t_stale();
    t_reset_clear();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule